// File: doc/BRIEF.md
# Single-Precision Round and Pack Unit

This unit takes an unpacked floating-point result and turns it into a finished 32-bit IEEE single-precision word. The result arrives as a sign, a 10-bit two's-complement exponent and a 32-bit significand that carries seven rounding bits below the usual fraction position. The unit also returns overflow, underflow and inexact flags. The caller supplies the exponent one below the true exponent. The significand's integer bit sits at bit 30, so packing by addition folds any rounding carry into the exponent field. A per-item select lets the unit normalize a significand that is not already normalized.

Data moves through a two-stage pipeline with valid/ready handshakes on both sides. An item is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the first stage is empty or will be emptied on that edge, so a full pipeline with `out_ready` low stalls the producer. `out_valid` and the result fields hold steady until the consumer takes them with `out_ready`. When the output is not stalled, a result appears two clock edges after its item is accepted.

Top module: `rpk_round_pack`

## Requirements
- R1: An accepted item produces its result at the output after two clock edges when `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` and all result fields stay unchanged. `in_ready` is low when both stages hold data and the output is stalled.
- R2: The rounding increment depends on the mode code. It is 0x40 for mode 0 (nearest, ties to even) and 0 for mode 1 (toward zero). Mode 2 (toward minus infinity) uses 0x7F for negative values and 0 for positive ones. Mode 3 (toward plus infinity) uses 0x7F for positive values and 0 for negative ones.
- R3: The rounded significand is (significand + increment) shifted right by 7. In mode 0, an exact tie (low seven bits equal to 0x40) clears bit 0 of the rounded significand. `out_inexact` is high whenever the final low seven bits are nonzero.
- R4: The word is sign<<31 plus the exponent's low 8 bits <<23 plus the rounded significand, so a rounding carry raises the exponent field. An exponent input of 126 with significand 0x40000000 gives 0x3F800000. A rounded significand of zero forces the exponent field to 0.
- R5: Overflow happens when the exponent is above 253, or when it equals 253 and significand plus increment reaches 0x80000000. Overflow raises both `out_overflow` and `out_inexact`, and never `out_underflow`.
- R6: On overflow the word is infinity with the input sign (exponent field 0xFF, fraction 0). When the rounding increment is 0, the word is one less than infinity, which is the largest finite magnitude (0x7F7FFFFF or 0xFF7FFFFF).
- R7: A negative exponent shifts the significand right by its magnitude, and a shift of 32 or more leaves only a sticky bit. Any one bit shifted out is ORed into bit 0. Rounding then proceeds with the exponent field at 0.
- R8: A value with a negative exponent is tiny in three cases: `in_tiny_before` is high, the exponent is below -1, or significand plus increment is below 0x80000000. `out_underflow` is high only for a tiny value whose post-shift low seven bits are nonzero.
- R9: With `in_norm_en` high and a nonzero significand, a significand whose bit 31 is clear is shifted left by (leading zeros - 1) and that amount is subtracted from the exponent. A significand with bit 31 set is shifted right by one with the lost bit ORed into bit 0, and the exponent is raised by one. A zero significand passes unchanged. With `in_norm_en` low the significand is used as given.
- R10: While `rst_n` is low the pipeline is empty: `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Unit can take an item this edge |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 10 | Two's-complement exponent, true exponent minus one |
| in_sig | input | 32 | Significand, integer bit at 30, rounding bits 6:0 |
| in_mode | input | 2 | Rounding mode code (see R2) |
| in_tiny_before | input | 1 | 1: tininess judged before rounding |
| in_norm_en | input | 1 | 1: normalize the significand first |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this edge |
| out_word | output | 32 | Packed single-precision word |
| out_overflow | output | 1 | Overflow flag |
| out_underflow | output | 1 | Underflow flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
A wrong rounding increment or tie handling shows up in the low fraction bits and the inexact flag of the very result that uses it, two edges after acceptance. A lost carry shows up in the exponent field of that same result. Faults on the subnormal path show up on that item's result as a wrong word or wrong flags, for example a dropped sticky bit, a wrong shift amount or a tininess decision taken at the wrong time. A broken hold or ready path shows up within one stalled cycle, as a changed output word or a dropped or duplicated item.

// File: rtl/rpk_pkg.sv
package rpk_pkg;
  localparam int SIG_W    = 32;               // unpacked significand width
  localparam int RND_W    = 7;                // rounding bits under the fraction
  localparam int EXP_W    = 10;               // exponent input width
  localparam int EI_W     = EXP_W + 2;        // internal exponent width with headroom
  localparam int FEXP_W   = 8;                // packed exponent field width
  localparam int FRAC_W   = 23;               // packed fraction field width
  localparam int WORD_W   = 1 + FEXP_W + FRAC_W;
  localparam int SUM_W    = SIG_W + 1;
  localparam int RS_W     = SUM_W - RND_W;    // rounded significand width
  localparam int LZ_W     = $clog2(SIG_W) + 1;
  localparam logic signed [EI_W-1:0] EXP_TOP = EI_W'((1 << FEXP_W) - 3);
  localparam logic [RND_W-1:0] INC_HALF = RND_W'(1 << (RND_W - 1));
  localparam logic [RND_W-1:0] INC_FULL = {RND_W{1'b1}};

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_TO_ZERO   = 2'd1,
    RM_DOWN      = 2'd2,
    RM_UP        = 2'd3
  } rmode_e;

  typedef struct packed {
    logic                   sign;
    logic signed [EI_W-1:0] exp;
    logic [SIG_W-1:0]       sig;
    logic [1:0]             mode;
    logic                   tin_before;
  } unp_t;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic              ovf;
    logic              unf;
    logic              inx;
  } res_t;
endpackage

// File: rtl/rpk_lzc.sv
module rpk_lzc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/rpk_norm.sv
module rpk_norm
  import rpk_pkg::*;
(
  input  logic                    en,
  input  logic [EXP_W-1:0]        exp_i,
  input  logic [SIG_W-1:0]        sig_i,
  output logic signed [EI_W-1:0]  exp_o,
  output logic [SIG_W-1:0]        sig_o
);
  logic [LZ_W-1:0]        lz;
  logic [LZ_W-1:0]        sh;
  logic signed [EI_W-1:0] exp_x;

  rpk_lzc #(.W(SIG_W), .CW(LZ_W)) u_lzc (.vec(sig_i), .cnt(lz));

  assign exp_x = EI_W'($signed(exp_i));
  assign sh    = lz - LZ_W'(1);

  always_comb begin
    exp_o = exp_x;
    sig_o = sig_i;
    if (en && (sig_i != '0)) begin
      if (lz == '0) begin
        sig_o = {1'b0, sig_i[SIG_W-1:2], sig_i[1] | sig_i[0]};
        exp_o = exp_x + EI_W'(1);
      end else begin
        sig_o = sig_i << sh;
        exp_o = exp_x - $signed({{(EI_W-LZ_W){1'b0}}, sh});
      end
    end
  end
endmodule

// File: rtl/rpk_round.sv
module rpk_round
  import rpk_pkg::*;
(
  input  unp_t u,
  output res_t r
);
  logic [RND_W-1:0]       inc;
  logic                   pre_big;
  logic                   neg;
  logic                   ovf;
  logic                   tiny;
  logic [EI_W-1:0]        amt;
  logic [SIG_W-1:0]       shr;
  logic                   lost;
  logic [SIG_W-1:0]       sig_d;
  logic [RND_W-1:0]       rb;
  logic [SUM_W-1:0]       sum;
  logic [RS_W-1:0]        rs;
  logic [FEXP_W-1:0]      e_f;
  logic                   rne;

  always_comb begin
    inc = '0;
    case (rmode_e'(u.mode))
      RM_NEAR_EVEN: inc = INC_HALF;
      RM_TO_ZERO:   inc = '0;
      RM_DOWN:      inc = u.sign ? INC_FULL : '0;
      RM_UP:        inc = u.sign ? '0 : INC_FULL;
      default:      inc = '0;
    endcase
  end

  assign rne     = (rmode_e'(u.mode) == RM_NEAR_EVEN);
  assign pre_big = ({1'b0, u.sig} + SUM_W'(inc)) >= (SUM_W'(1) << (SIG_W - 1));
  assign neg     = u.exp < 0;
  assign ovf     = (u.exp > EXP_TOP) || ((u.exp == EXP_TOP) && pre_big);
  assign tiny    = u.tin_before || (u.exp < -EI_W'(1)) || !pre_big;
  assign amt     = EI_W'(-u.exp);

  // right shift with sticky jamming
  always_comb begin
    shr  = u.sig >> amt[$clog2(SIG_W)-1:0];
    lost = |(u.sig & ~({SIG_W{1'b1}} << amt[$clog2(SIG_W)-1:0]));
    if (!neg) begin
      sig_d = u.sig;
    end else if (amt >= EI_W'(SIG_W)) begin
      sig_d = {{(SIG_W-1){1'b0}}, |u.sig};
    end else begin
      sig_d = {shr[SIG_W-1:1], shr[0] | lost};
    end
  end

  assign rb  = sig_d[RND_W-1:0];
  assign sum = {1'b0, sig_d} + SUM_W'(inc);

  always_comb begin
    rs = sum[SUM_W-1:RND_W];
    if (rne && (rb == INC_HALF)) rs[0] = 1'b0;
    e_f = neg ? '0 : u.exp[FEXP_W-1:0];
    if (rs == '0) e_f = '0;
  end

  always_comb begin
    if (ovf) begin
      r.word = {u.sign, {FEXP_W{1'b1}}, {FRAC_W{1'b0}}}
               - WORD_W'(inc == '0);
      r.ovf  = 1'b1;
      r.unf  = 1'b0;
      r.inx  = 1'b1;
    end else begin
      r.word = {u.sign, {(WORD_W-1){1'b0}}}
               + {1'b0, e_f, {FRAC_W{1'b0}}}
               + {{(WORD_W-RS_W){1'b0}}, rs};
      r.ovf  = 1'b0;
      r.inx  = rb != '0;
      r.unf  = neg && tiny && (rb != '0);
    end
  end
endmodule

// File: rtl/rpk_round_pack.sv
module rpk_round_pack
  import rpk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_sign,
  input  logic [EXP_W-1:0]    in_exp,
  input  logic [SIG_W-1:0]    in_sig,
  input  logic [1:0]          in_mode,
  input  logic                in_tiny_before,
  input  logic                in_norm_en,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_word,
  output logic                out_overflow,
  output logic                out_underflow,
  output logic                out_inexact
);
  logic signed [EI_W-1:0] n_exp;
  logic [SIG_W-1:0]       n_sig;
  unp_t                   s1_q;
  logic                   v1_q;
  res_t                   s2_d;
  res_t                   s2_q;
  logic                   v2_q;
  logic                   adv1;
  logic                   adv2;

  rpk_norm u_norm (
    .en    (in_norm_en),
    .exp_i (in_exp),
    .sig_i (in_sig),
    .exp_o (n_exp),
    .sig_o (n_sig)
  );

  rpk_round u_round (.u(s1_q), .r(s2_d));

  assign adv2     = !v2_q || out_ready;
  assign adv1     = !v1_q || adv2;
  assign in_ready = adv1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      if (adv1) v1_q <= in_valid;
      if (adv2) v2_q <= v1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (adv1 && in_valid) begin
      s1_q.sign       <= in_sign;
      s1_q.exp        <= n_exp;
      s1_q.sig        <= n_sig;
      s1_q.mode       <= in_mode;
      s1_q.tin_before <= in_tiny_before;
    end
    if (adv2 && v1_q) s2_q <= s2_d;
  end

  assign out_valid     = v2_q;
  assign out_word      = s2_q.word;
  assign out_overflow  = s2_q.ovf;
  assign out_underflow = s2_q.unf;
  assign out_inexact   = s2_q.inx;
endmodule

// File: rtl/rpk_checker.sv
module rpk_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_word,
  input logic        out_overflow,
  input logic        out_underflow,
  input logic        out_inexact
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid); // R1
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_word) && $stable(out_overflow)
      && $stable(out_underflow) && $stable(out_inexact)); // R1
  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |-> out_inexact && !out_underflow); // R5
  AST_SAT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |->
      (out_word[30:0] == 31'h7F800000) || (out_word[30:0] == 31'h7F7FFFFF)); // R6
  AST_UNF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_underflow |-> out_inexact); // R8
  AST_UNF_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_underflow |-> out_word[30:23] <= 8'd1); // R7
endmodule

bind rpk_round_pack rpk_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_word      (out_word),
  .out_overflow  (out_overflow),
  .out_underflow (out_underflow),
  .out_inexact   (out_inexact)
);

// File: tb/tb_rpk_round_pack.sv
module tb_rpk_round_pack;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;

  typedef struct packed {
    logic        sign;
    logic [9:0]  exp;
    logic [31:0] sig;
    logic [1:0]  mode;
    logic        tb4;
    logic        norm;
    logic [31:0] word;
    logic        ovf;
    logic        unf;
    logic        inx;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'h07E, 32'h40000000, 2'd0, 1'b0, 1'b0, 32'h3F800000, 1'b0, 1'b0, 1'b0, 4'd4}, // R4 one
    '{1'b0, 10'h07E, 32'h40000040, 2'd0, 1'b0, 1'b0, 32'h3F800000, 1'b0, 1'b0, 1'b1, 4'd3}, // R3 tie to even down
    '{1'b0, 10'h07E, 32'h400000C0, 2'd0, 1'b0, 1'b0, 32'h3F800002, 1'b0, 1'b0, 1'b1, 4'd3}, // R3 tie to even up
    '{1'b0, 10'h07E, 32'h4000007F, 2'd1, 1'b0, 1'b0, 32'h3F800000, 1'b0, 1'b0, 1'b1, 4'd2}, // R2 toward zero
    '{1'b0, 10'h07E, 32'h40000001, 2'd3, 1'b0, 1'b0, 32'h3F800001, 1'b0, 1'b0, 1'b1, 4'd2}, // R2 up positive
    '{1'b1, 10'h07E, 32'h40000001, 2'd3, 1'b0, 1'b0, 32'hBF800000, 1'b0, 1'b0, 1'b1, 4'd2}, // R2 up negative
    '{1'b1, 10'h07E, 32'h40000001, 2'd2, 1'b0, 1'b0, 32'hBF800001, 1'b0, 1'b0, 1'b1, 4'd2}, // R2 down negative
    '{1'b0, 10'h07E, 32'h40000001, 2'd2, 1'b0, 1'b0, 32'h3F800000, 1'b0, 1'b0, 1'b1, 4'd2}, // R2 down positive
    '{1'b0, 10'h07E, 32'h7FFFFFC0, 2'd0, 1'b0, 1'b0, 32'h40000000, 1'b0, 1'b0, 1'b1, 4'd4}, // R4 carry into exponent
    '{1'b0, 10'h0FE, 32'h40000000, 2'd0, 1'b0, 1'b0, 32'h7F800000, 1'b1, 1'b0, 1'b1, 4'd5}, // R5 exponent too big
    '{1'b0, 10'h0FD, 32'h7FFFFFC0, 2'd0, 1'b0, 1'b0, 32'h7F800000, 1'b1, 1'b0, 1'b1, 4'd5}, // R5 edge with carry
    '{1'b1, 10'h0FD, 32'h7FFFFFC0, 2'd1, 1'b0, 1'b0, 32'hFF7FFFFF, 1'b0, 1'b0, 1'b1, 4'd5}, // R5 edge, no carry
    '{1'b0, 10'h12C, 32'h40000000, 2'd1, 1'b0, 1'b0, 32'h7F7FFFFF, 1'b1, 1'b0, 1'b1, 4'd6}, // R6 saturate finite
    '{1'b1, 10'h12C, 32'h40000000, 2'd3, 1'b0, 1'b0, 32'hFF7FFFFF, 1'b1, 1'b0, 1'b1, 4'd6}, // R6 saturate negative
    '{1'b1, 10'h12C, 32'h40000000, 2'd2, 1'b0, 1'b0, 32'hFF800000, 1'b1, 1'b0, 1'b1, 4'd6}, // R6 negative infinity
    '{1'b0, 10'h3FF, 32'h40000000, 2'd0, 1'b0, 1'b0, 32'h00400000, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 exact subnormal
    '{1'b0, 10'h3FD, 32'h40000001, 2'd0, 1'b0, 1'b0, 32'h00100000, 1'b0, 1'b1, 1'b1, 4'd7}, // R7 sticky jam
    '{1'b0, 10'h3FF, 32'h7FFFFFC0, 2'd0, 1'b0, 1'b0, 32'h00800000, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 after rounding
    '{1'b0, 10'h3FF, 32'h7FFFFFC0, 2'd0, 1'b1, 1'b0, 32'h00800000, 1'b0, 1'b1, 1'b1, 4'd8}, // R8 before rounding
    '{1'b0, 10'h200, 32'h40000000, 2'd0, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b1, 1'b1, 4'd8}, // R8 huge shift
    '{1'b0, 10'h200, 32'h40000000, 2'd3, 1'b0, 1'b0, 32'h00000001, 1'b0, 1'b1, 1'b1, 4'd7}, // R7 sticky rounds up
    '{1'b0, 10'h09C, 32'h00000001, 2'd0, 1'b0, 1'b1, 32'h3F800000, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 shift left 30
    '{1'b0, 10'h07D, 32'h80000000, 2'd0, 1'b0, 1'b1, 32'h3F800000, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 top bit set
    '{1'b0, 10'h07D, 32'h80000001, 2'd0, 1'b0, 1'b1, 32'h3F800000, 1'b0, 1'b0, 1'b1, 4'd9}, // R9 right shift jam
    '{1'b1, 10'h064, 32'h00000000, 2'd0, 1'b0, 1'b1, 32'h80000000, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 zero passes
    '{1'b0, 10'h09C, 32'h00000001, 2'd0, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0, 1'b1, 4'd9}, // R9 bypass
    '{1'b0, 10'h07E, 32'h00000001, 2'd0, 1'b0, 1'b0, 32'h00000000, 1'b0, 1'b0, 1'b1, 4'd4}  // R4 zero forces exp
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sign = 1'b0;
  logic [9:0]  in_exp = '0;
  logic [31:0] in_sig = '0;
  logic [1:0]  in_mode = '0;
  logic        in_tiny_before = 1'b0;
  logic        in_norm_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic        out_overflow;
  logic        out_underflow;
  logic        out_inexact;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rpk_round_pack dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig), .in_mode(in_mode),
    .in_tiny_before(in_tiny_before), .in_norm_en(in_norm_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_overflow(out_overflow), .out_underflow(out_underflow),
    .out_inexact(out_inexact)
  );

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_sign        = v.sign;
    in_exp         = v.exp;
    in_sig         = v.sig;
    in_mode        = v.mode;
    in_tiny_before = v.tb4;
    in_norm_en     = v.norm;
  endtask

  function automatic logic [34:0] pack_exp(input vec_t v);
    return {v.word, v.ovf, v.unf, v.inx};
  endfunction

  function automatic logic [34:0] pack_out();
    return {out_word, out_overflow, out_underflow, out_inexact};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired R1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset out_valid", {34'b0, out_valid}, 35'd0);
    check("R10 reset in_ready", {34'b0, in_ready}, 35'd1);
    rst_n = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (!out_valid || pack_out() !== pack_exp(VECS[i])) begin
        errors++;
        $display("FAIL R%0d vec %0d actual=%b/%h expected=1/%h", VECS[i].req, i,
                 out_valid, pack_out(), pack_exp(VECS[i]));
      end
    end

    // back-pressure: R1
    @(negedge clk);
    out_ready = 1'b0;
    drive(VECS[0]);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drive(VECS[2]);
    @(posedge clk);
    @(negedge clk);
    check("R1 full stalls input", {34'b0, in_ready}, 35'd0);
    check("R1 first result held", {out_valid, out_word, 2'b0}, {1'b1, VECS[0].word, 2'b0});
    drive(VECS[9]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 held across stall", {out_valid, out_word, 2'b0}, {1'b1, VECS[0].word, 2'b0});
    check("R1 still stalled", {34'b0, in_ready}, 35'd0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 second result", {out_valid, out_word, 2'b0}, {1'b1, VECS[2].word, 2'b0});
    @(posedge clk);
    @(negedge clk);
    check("R1 third result", {out_valid, pack_out()[34:1]}, {1'b1, pack_exp(VECS[9])[34:1]});
    @(posedge clk);
    @(negedge clk);
    check("R1 drained", {34'b0, out_valid}, 35'd0);

    // reset mid-flight clears the pipeline: R10
    drive(VECS[1]);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10 reset flushes", {33'b0, out_valid, in_ready}, 35'd1);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule